// File: doc/BRIEF.md
# Remote Defect Indicator Monitor

This block sits behind a receive E3 framer and watches the one-bit far-end remote-defect indication that the framer pulls out of every received frame. It filters that bit with a run-length rule. The remote-defect condition is declared only after an unbroken run of frames carrying the indication. It is withdrawn only after an unbroken run of frames without it. The run length is 3 or 5 frames and is picked at runtime by a single configuration bit.

Every change of the declared condition, whether it rises or falls, sets a sticky change status bit. Software clears that bit with a write-1-to-clear access. When the interrupt enable is set, a set status bit pulls an active-low interrupt pin. Frames that arrive while the framer reports loss of frame sync are ignored, so a resync does not break a run that is under way.

Top module: `rdi_monitor`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `defect_o` is 0, `chg_sticky_o` is 0, `irq_n_o` is 1, and both run counts are zero.
- R2: With `thr_sel` = 0, the defect is declared at the clock edge that accepts the 3rd consecutive accepted frame with `rdi_bit` = 1.
- R3: With `thr_sel` = 1, the defect is declared at the clock edge that accepts the 5th consecutive accepted frame with `rdi_bit` = 1.
- R4: While the defect is not declared, an accepted frame with `rdi_bit` = 0 restarts the declare run from zero.
- R5: While the defect is declared, it is withdrawn after the same selected number (3 or 5) of consecutive accepted frames with `rdi_bit` = 0. An accepted frame with `rdi_bit` = 1 restarts that run.
- R6: A frame is accepted only when `frame_stb` and `sync_ok` are both 1. A strobe with `sync_ok` = 0 changes nothing, and both runs keep their counts.
- R7: Every change of `defect_o`, in either direction, sets `chg_sticky_o` at the same edge. The bit stays 1 until it is cleared.
- R8: A cycle with `clr_stb` = 1 and `clr_val` = 1 clears `chg_sticky_o` at the next edge. With `clr_val` = 0 the access has no effect.
- R9: If a change of `defect_o` and a clear access fall in the same cycle, `chg_sticky_o` ends up 1.
- R10: `irq_n_o` is 0 exactly when `chg_sticky_o` = 1 and `irq_en` = 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| rdi_bit | input | 1 | Remote-defect bit of the current frame, valid with `frame_stb` |
| sync_ok | input | 1 | Framer is in frame sync |
| thr_sel | input | 1 | Run length select: 0 gives 3 frames, 1 gives 5 frames |
| irq_en | input | 1 | Interrupt enable for the change status |
| clr_stb | input | 1 | Status write strobe |
| clr_val | input | 1 | Write data; 1 clears the change status |
| defect_o | output | 1 | Remote-defect condition declared (read-only status) |
| chg_sticky_o | output | 1 | Sticky change-of-condition status |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The embedded properties assume that `frame_stb` and `clr_stb` are single-cycle pulses. They also assume that `thr_sel` does not move in the middle of a run. The run-count bound therefore holds for the larger limit, and the declare and withdraw instants line up with the selected limit. The bench changes `thr_sel` only while reset is held, and it drives every strobe for exactly one cycle on the falling edge. It sweeps every 5-frame sequence of (bit, sync) pairs for both limits, starting both from the clear state and from the declared state. A few directed sequences then cover the clear priority and the no-op write.

// File: rtl/rdm_pkg.sv
// Package rdm_pkg
// Shared types for the remote defect monitor.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package rdm_pkg;

    // Declared state of the remote-defect condition
    typedef enum logic {
        RDM_CLEAR    = 1'b0,
        RDM_DECLARED = 1'b1
    } rdm_state_e;

    // Select the active run length from the configuration bit
    function automatic int unsigned rdm_limit(input logic sel,
                                              input int unsigned lo,
                                              input int unsigned hi);
        return sel ? hi : lo;
    endfunction

endpackage

// File: rtl/rdm_persist.sv
// Module rdm_persist
// Counts consecutive accepted frames whose bit equals the wanted value.
// It raises fire on the frame that completes a run of 'limit'.
// Assumes: step is a one-cycle pulse; limit >= 1 and limit <= MAX_RUN;
//          en changes only on cycles where step is high.
module rdm_persist #(
    parameter int unsigned MAX_RUN = 5,
    parameter int unsigned CNT_W   = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             match,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    // Run is complete when this frame is the limit-th match
    assign at_end = (cnt >= (limit - 1'b1));
    assign fire   = en && step && match && at_end;

    // Run counter: restart on a mismatch, on fire, or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (step) begin
            if (!match || at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // The count never reaches the largest run length
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_RUN - 1));

    // Without an accepted frame the count holds
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    // A mismatching frame restarts the run
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !match) |=> (cnt == '0));

endmodule

// File: rtl/rdm_irq.sv
// Module rdm_irq
// Sticky change status with write-1-to-clear and an active-low pin.
// Assumes: chg is a one-cycle pulse on each change of the defect state.
module rdm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic chg,
    input  logic clr_stb,
    input  logic clr_val,
    input  logic irq_en,
    output logic sticky,
    output logic irq_n
);

    logic clr_hit;

    assign clr_hit = clr_stb && clr_val;

    // Sticky bit: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (chg) begin
            sticky <= 1'b1;
        end else if (clr_hit) begin
            sticky <= 1'b0;
        end
    end

    // Pin is low while the status is set and enabled
    assign irq_n = !(sticky && irq_en);

    // A change always leaves the status set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> sticky);

    // The status only falls because of a clear access
    assert_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky) |-> $past(clr_hit));

    // The pin is never low while interrupts are disabled
    assert_pin_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> irq_en);

endmodule

// File: rtl/rdi_monitor.sv
// Module rdi_monitor
// Run-length filter for the per-frame remote-defect bit.
// It declares and withdraws the condition and raises a change interrupt.
// Assumes: frame_stb is a one-cycle pulse; thr_sel is held stable within a run.
module rdi_monitor #(
    parameter int unsigned THR_LO = 3,
    parameter int unsigned THR_HI = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic rdi_bit,
    input  logic sync_ok,
    input  logic thr_sel,
    input  logic irq_en,
    input  logic clr_stb,
    input  logic clr_val,
    output logic defect_o,
    output logic chg_sticky_o,
    output logic irq_n_o
);
    import rdm_pkg::*;

    localparam int unsigned MAX_RUN = (THR_HI > THR_LO) ? THR_HI : THR_LO;
    localparam int unsigned CNT_W   = $clog2(MAX_RUN + 1);

    rdm_state_e       state;
    logic             step;
    logic [CNT_W-1:0] limit;
    logic [1:0]       fire;
    logic             chg;

    // A frame counts only while the framer is in sync
    assign step  = frame_stb && sync_ok;
    assign limit = CNT_W'(rdm_limit(thr_sel, THR_LO, THR_HI));

    // Two run filters: index 0 declares on ones, index 1 withdraws on zeros
    for (genvar g = 0; g < 2; g++) begin : g_run
        rdm_persist #(
            .MAX_RUN (MAX_RUN),
            .CNT_W   (CNT_W)
        ) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .en    ((g == 0) ? (state == RDM_CLEAR) : (state == RDM_DECLARED)),
            .step  (step),
            .match ((g == 0) ? rdi_bit : !rdi_bit),
            .limit (limit),
            .fire  (fire[g])
        );
    end

    assign chg = |fire;

    // Defect state toggles whenever the active filter completes its run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RDM_CLEAR;
        end else if (fire[0]) begin
            state <= RDM_DECLARED;
        end else if (fire[1]) begin
            state <= RDM_CLEAR;
        end
    end

    assign defect_o = (state == RDM_DECLARED);

    rdm_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg     (chg),
        .clr_stb (clr_stb),
        .clr_val (clr_val),
        .irq_en  (irq_en),
        .sticky  (chg_sticky_o),
        .irq_n   (irq_n_o)
    );

    // Declaring needs an accepted frame carrying the indication
    assert_declare_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(defect_o) |-> $past(step && rdi_bit));

    // Withdrawing needs an accepted frame without the indication
    assert_withdraw_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(defect_o) |-> $past(step && !rdi_bit));

    // Each change of the condition is reflected in the status
    assert_change_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (defect_o != $past(defect_o)) |-> chg_sticky_o);

    // Both filters never fire together
    assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fire) <= 1);

endmodule

// File: tb/rdi_monitor_bench.sv
module rdi_monitor_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, frame_stb, rdi_bit, sync_ok, thr_sel, irq_en, clr_stb, clr_val;
    logic defect_o, chg_sticky_o, irq_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state, kept from the requirements
    int m_r1, m_r0, m_lim;
    bit m_def, m_sticky;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdi_monitor u_rdi_monitor (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rdi_bit(rdi_bit),
        .sync_ok(sync_ok), .thr_sel(thr_sel), .irq_en(irq_en),
        .clr_stb(clr_stb), .clr_val(clr_val), .defect_o(defect_o),
        .chg_sticky_o(chg_sticky_o), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "defect", defect_o, m_def);
        chk(req, "sticky", chg_sticky_o, m_sticky);
        chk("R10", "irq_n", irq_n_o, !(m_sticky && irq_en));
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n = 0; frame_stb = 0; rdi_bit = 0; sync_ok = 0;
        clr_stb = 0; clr_val = 0; thr_sel = sel; irq_en = 1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        m_r1 = 0; m_r0 = 0; m_def = 0; m_sticky = 0;
        m_lim = sel ? 5 : 3;
        chk("R1", "defect", defect_o, 1'b0);
        chk("R1", "sticky", chg_sticky_o, 1'b0);
        chk("R1", "irq_n", irq_n_o, 1'b1);
    endtask

    // One frame, optionally with a status write in the same cycle
    task automatic frame(input logic b, input logic v, input logic cs, input logic cv);
        bit chg = 0;
        @(negedge clk);
        frame_stb = 1; rdi_bit = b; sync_ok = v; clr_stb = cs; clr_val = cv;
        if (v) begin
            if (!m_def) begin
                if (b) begin
                    m_r1++;
                    if (m_r1 >= m_lim) begin m_def = 1; m_r1 = 0; chg = 1; end
                end else m_r1 = 0;
            end else begin
                if (!b) begin
                    m_r0++;
                    if (m_r0 >= m_lim) begin m_def = 0; m_r0 = 0; chg = 1; end
                end else m_r0 = 0;
            end
        end
        if (chg) m_sticky = 1;
        else if (cs && cv) m_sticky = 0;
        @(negedge clk);
        frame_stb = 0; clr_stb = 0; clr_val = 0; sync_ok = 1;
    endtask

    task automatic wclr(input logic cv);
        @(negedge clk);
        clr_stb = 1; clr_val = cv;
        if (cv) m_sticky = 0;
        @(negedge clk);
        clr_stb = 0; clr_val = 0;
    endtask

    initial begin
        rst_n = 0; frame_stb = 0; rdi_bit = 0; sync_ok = 0;
        thr_sel = 0; irq_en = 0; clr_stb = 0; clr_val = 0;
        // Sweep: both limits, start clear or declared, every 5-frame (bit,sync) sequence
        for (int sel = 0; sel < 2; sel++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int pat = 0; pat < 1024; pat++) begin
                    do_reset(sel[0]);
                    if (pre == 1) begin
                        for (int k = 0; k < m_lim; k++) frame(1'b1, 1'b1, 1'b0, 1'b0);
                        chk(sel ? "R3" : "R2", "declare", defect_o, 1'b1);
                        chk("R7", "sticky", chg_sticky_o, 1'b1);
                        wclr(1'b1);
                        chk("R8", "w1c", chg_sticky_o, 1'b0);
                    end
                    irq_en = pat[0] ^ sel[0];
                    for (int f = 0; f < 5; f++) begin
                        frame(pat[2*f], pat[2*f+1], 1'b0, 1'b0);
                        chk_all(pre ? "R5" : (sel ? "R3" : "R2"));
                    end
                end
            end
        end

        // R6: invalid frames between ones do not break the run
        do_reset(1'b0);
        frame(1, 1, 0, 0); frame(1, 1, 0, 0);
        frame(0, 0, 0, 0); frame(0, 0, 0, 0);
        chk("R6", "held", defect_o, 1'b0);
        frame(1, 1, 0, 0);
        chk("R6", "declare after hold", defect_o, 1'b1);

        // R4: a zero restarts the declare run
        do_reset(1'b0);
        frame(1, 1, 0, 0); frame(1, 1, 0, 0); frame(0, 1, 0, 0);
        frame(1, 1, 0, 0); frame(1, 1, 0, 0);
        chk("R4", "restart", defect_o, 1'b0);
        frame(1, 1, 0, 0);
        chk("R4", "declare", defect_o, 1'b1);

        // R8: write with value 0 leaves the status alone
        wclr(1'b0);
        chk("R8", "no-op write", chg_sticky_o, 1'b1);
        wclr(1'b1);
        chk("R8", "cleared", chg_sticky_o, 1'b0);
        chk("R10", "pin released", irq_n_o, 1'b1);

        // R9: withdraw and clear in the same cycle, set wins
        frame(0, 1, 0, 0); frame(0, 1, 0, 0);
        frame(0, 1, 1, 1);
        chk("R5", "withdrawn", defect_o, 1'b0);
        chk("R9", "set wins", chg_sticky_o, 1'b1);
        chk("R10", "pin low", irq_n_o, 1'b0);
        irq_en = 0;
        #1;
        chk("R10", "pin disabled", irq_n_o, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule